// File: doc/BRIEF.md
# ADC Result Byte Formatter with Read Interlock

This block takes the 10-bit result of a single-channel conversion and stores it as two bytes that a byte-wide read bus reaches at two fixed addresses. The mode input decides how the result bits are laid out across the two bytes. There are two left-justified layouts, one unsigned and one with the sign bit inverted. There is also a right-justified layout, and an 8-bit truncated layout that uses only the low byte.

In the three paired layouts, software reads the upper byte first and the lower byte second. Reading the upper byte arms an interlock. While it is armed, the lower byte stays frozen and every conversion that completes is dropped. Reading the lower byte disarms it. The truncated layout has no interlock: every completed conversion is stored. A change of mode also disarms a pending interlock.

Top module: `adc_result_fmt`

## Requirements
- R1: `mode_i` encoding: 0 = left unsigned, 1 = left signed, 2 = right justified, 3 = 8-bit truncated. In left unsigned mode the upper byte holds result bits 9..2, and the lower byte holds result bits 1..0 in its bits 7..6 with zeros below.
- R2: Left signed mode uses the same layout as R1, except that upper byte bit 7 holds the inverse of result bit 9.
- R3: In right justified mode the upper byte holds result bits 9..8 in its bits 1..0 with zeros above. The lower byte holds result bits 7..0.
- R4: In truncated mode the lower byte holds result bits 9..2 and the upper byte reads 0. Every completed conversion updates the bytes, and a read never arms the interlock.
- R5: A read with `rd_en_i` high returns the upper byte at address 0x3D and the lower byte at 0x3E, combinationally in the same cycle. `rd_data_o` is 0 when `rd_en_i` is low or when the address is any other value.
- R6: While the interlock is disarmed, a completed conversion (`res_done_i` high) is stored and can be read from the next cycle.
- R7: In a paired mode, a read of the upper byte arms the interlock. While it is armed, completed conversions are dropped and both bytes keep their values.
- R8: A read of the lower byte disarms the interlock. A read of the lower byte while the interlock is disarmed does not arm it.
- R9: A conversion that completes in the same cycle as the read that disarms the interlock is dropped. A conversion that completes in the following cycle is stored.
- R10: A change of `mode_i` disarms the interlock. The new layout applies to the next stored result.
- R11: Reset disarms the interlock. The stored bytes are not cleared by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| res_i | input | 10 | Conversion result |
| res_done_i | input | 1 | Result valid strobe, one cycle per conversion |
| mode_i | input | 2 | Layout select (encoding in R1) |
| rd_en_i | input | 1 | Read strobe |
| rd_addr_i | input | 8 | Read byte address |
| rd_data_o | output | 8 | Read data |

## Verification
The assertions assume three things about the inputs. `mode_i` changes only on clock edges. A read strobe presents one address per cycle. `res_done_i` is a single-cycle pulse whose `res_i` is valid in that cycle. The bench drives every input on the falling edge and holds it for whole cycles. It issues exactly one address per read, and it raises `res_done_i` together with a defined result. Because of this, the stored bytes never take unknown values after the first accepted conversion. Before that first conversion, the bench performs no data reads.

// File: rtl/adc_fmt_pkg.sv
package adc_fmt_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [1:0] {
    MODE_LEFT_U = 2'd0,
    MODE_LEFT_S = 2'd1,
    MODE_RIGHT  = 2'd2,
    MODE_TRUNC  = 2'd3
  } adc_mode_e;

  typedef struct packed {
    logic [BYTE_W-1:0] hi;
    logic [BYTE_W-1:0] lo;
  } byte_pair_t;
endpackage

// File: rtl/adc_fmt_pack.sv
module adc_fmt_pack
  import adc_fmt_pkg::*;
#(
  parameter int unsigned RES_W = 10
) (
  input  logic [RES_W-1:0] res_i,
  input  adc_mode_e        mode_i,
  output byte_pair_t       pair_o
);
  localparam int unsigned LSB_W = RES_W - BYTE_W;
  localparam int unsigned PAD_W = BYTE_W - LSB_W;

  logic [BYTE_W-1:0] top_byte;
  logic [BYTE_W-1:0] left_lo;
  logic [BYTE_W-1:0] right_hi;

  assign top_byte = res_i[RES_W-1 -: BYTE_W];
  assign left_lo  = {res_i[LSB_W-1:0], {PAD_W{1'b0}}};
  assign right_hi = {{PAD_W{1'b0}}, res_i[RES_W-1:BYTE_W]};

  always_comb begin
    unique case (mode_i)
      MODE_LEFT_U: pair_o = '{hi: top_byte, lo: left_lo};
      MODE_LEFT_S: pair_o = '{hi: {~top_byte[BYTE_W-1], top_byte[BYTE_W-2:0]}, lo: left_lo};
      MODE_RIGHT:  pair_o = '{hi: right_hi, lo: res_i[BYTE_W-1:0]};
      default:     pair_o = '{hi: '0, lo: top_byte};
    endcase
  end

  always_comb begin
    if (mode_i == MODE_TRUNC) a_r4_trunc_hi_zero: assert (pair_o.hi == '0);
  end
endmodule

// File: rtl/adc_fmt_lock.sv
module adc_fmt_lock
  import adc_fmt_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  adc_mode_e mode_i,
  input  logic      rd_hi_i,
  input  logic      rd_lo_i,
  input  logic      done_i,
  output logic      accept_o,
  output logic      lock_o
);
  adc_mode_e mode_q;
  logic      lock_q;
  logic      mode_chg;
  logic      trunc;

  assign trunc    = (mode_i == MODE_TRUNC);
  assign mode_chg = (mode_i != mode_q);
  // lock_q sampled before any same-cycle release: a result in the release cycle drops
  assign accept_o = done_i && (trunc || !lock_q);
  assign lock_o   = lock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_LEFT_U;
      lock_q <= 1'b0;
    end else begin
      mode_q <= mode_i;
      if (mode_chg || rd_lo_i) lock_q <= 1'b0;
      else if (rd_hi_i && !trunc) lock_q <= 1'b1;
    end
  end

  a_r8_lo_releases: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_lo_i |=> !lock_q);
  a_r10_mode_chg_releases: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_chg |=> !lock_q);
  a_r4_trunc_no_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trunc |=> !lock_q);
  a_r7_hi_arms: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_hi_i && !trunc && !mode_chg) |=> lock_q);
  a_r9_release_cycle_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_q && !trunc) |-> !accept_o);
endmodule

// File: rtl/adc_fmt_regs.sv
module adc_fmt_regs
  import adc_fmt_pkg::*;
#(
  parameter int unsigned ADDR_W  = 8,
  parameter logic [ADDR_W-1:0] HI_ADDR = 8'h3D,
  parameter logic [ADDR_W-1:0] LO_ADDR = 8'h3E
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  byte_pair_t        pair_i,
  input  logic              lock_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic              rd_hi_o,
  output logic              rd_lo_o,
  output logic [BYTE_W-1:0] rd_data_o
);
  byte_pair_t data_q;

  assign rd_hi_o = rd_en_i && (rd_addr_i == HI_ADDR);
  assign rd_lo_o = rd_en_i && (rd_addr_i == LO_ADDR);

  // contents intentionally survive reset
  always_ff @(posedge clk_i) begin
    if (wr_i) data_q <= pair_i;
  end

  always_comb begin
    if (rd_hi_o)      rd_data_o = data_q.hi;
    else if (rd_lo_o) rd_data_o = data_q.lo;
    else              rd_data_o = '0;
  end

  a_r7_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_i && !wr_i) |=> $stable(data_q));
  a_r5_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |-> rd_data_o == '0);
  a_r6_stored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> data_q == $past(pair_i));
endmodule

// File: rtl/adc_result_fmt.sv
module adc_result_fmt
  import adc_fmt_pkg::*;
#(
  parameter int unsigned RES_W  = 10,
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] HI_ADDR = 8'h3D,
  parameter logic [ADDR_W-1:0] LO_ADDR = 8'h3E
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [RES_W-1:0]  res_i,
  input  logic              res_done_i,
  input  logic [1:0]        mode_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [BYTE_W-1:0] rd_data_o
);
  adc_mode_e  mode;
  byte_pair_t pair;
  logic       accept;
  logic       lock;
  logic       rd_hi;
  logic       rd_lo;

  assign mode = adc_mode_e'(mode_i);

  adc_fmt_pack #(.RES_W(RES_W)) u_pack (
    .res_i  (res_i),
    .mode_i (mode),
    .pair_o (pair)
  );

  adc_fmt_lock u_lock (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .mode_i   (mode),
    .rd_hi_i  (rd_hi),
    .rd_lo_i  (rd_lo),
    .done_i   (res_done_i),
    .accept_o (accept),
    .lock_o   (lock)
  );

  adc_fmt_regs #(.ADDR_W(ADDR_W), .HI_ADDR(HI_ADDR), .LO_ADDR(LO_ADDR)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (accept),
    .pair_i    (pair),
    .lock_i    (lock),
    .rd_en_i   (rd_en_i),
    .rd_addr_i (rd_addr_i),
    .rd_hi_o   (rd_hi),
    .rd_lo_o   (rd_lo),
    .rd_data_o (rd_data_o)
  );

  a_r11_reset_unlocked: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> !lock);
  a_r4_trunc_always_stores: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_done_i && mode == MODE_TRUNC) |-> accept);
endmodule

// File: tb/adc_result_fmt_bench.sv
module adc_result_fmt_bench;
  localparam logic [7:0] HI = 8'h3D;
  localparam logic [7:0] LO = 8'h3E;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] res = '0;
  logic       done = 1'b0;
  logic [1:0] mode = 2'd0;
  logic       rd_en = 1'b0;
  logic [7:0] rd_addr = '0;
  logic [7:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  typedef struct { logic [7:0] exp; string tag; } item_t;
  item_t sb[$];

  always #4 clk = ~clk;

  adc_result_fmt u_adc_result_fmt (
    .clk_i(clk), .rst_ni(rst_n), .res_i(res), .res_done_i(done),
    .mode_i(mode), .rd_en_i(rd_en), .rd_addr_i(rd_addr), .rd_data_o(rd_data)
  );

  function automatic logic [7:0] f_hi(input logic [1:0] m, input logic [9:0] v);
    case (m)
      2'd0: return v[9:2];
      2'd1: return {~v[9], v[8:2]};
      2'd2: return {6'b0, v[9:8]};
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] f_lo(input logic [1:0] m, input logic [9:0] v);
    case (m)
      2'd0, 2'd1: return {v[1:0], 6'b0};
      2'd2: return v[7:0];
      default: return v[9:2];
    endcase
  endfunction

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // monitor: compares each read against the scoreboard head
  always begin
    @(negedge clk);
    #2;
    if (rd_en) begin
      if (sb.size() == 0) check(rd_data, 8'hxx, "unexpected read");
      else begin
        item_t it;
        it = sb.pop_front();
        check(rd_data, it.exp, it.tag);
      end
    end
  end

  task automatic conv(input logic [9:0] v);
    @(negedge clk); done = 1'b1; res = v;
    @(negedge clk); done = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk); rd_en = 1'b1; rd_addr = a;
    sb.push_back('{exp, tag});
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic set_mode(input logic [1:0] m);
    @(negedge clk); mode = m;
  endtask

  initial begin
    #(8 * 200000);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    if (!finished) begin
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #2;
    check(rd_data, 8'h00, "R5 idle after reset");

    // R11/R1: unlocked after reset, left unsigned layout
    conv(10'h2A5);
    rd(HI, f_hi(0, 10'h2A5), "R1 left-u hi");
    rd(LO, f_lo(0, 10'h2A5), "R1 left-u lo");
    rd(8'h40, 8'h00, "R5 other address");

    set_mode(2'd1);
    conv(10'h155);
    rd(HI, 8'hD5, "R2 signed hi");
    rd(LO, 8'h40, "R2 signed lo");
    conv(10'h3FF);
    rd(HI, 8'h7F, "R2 signed hi msb set");
    rd(LO, 8'hC0, "R2 signed lo");

    set_mode(2'd2);
    conv(10'h3C7);
    rd(HI, 8'h03, "R3 right hi");
    rd(LO, 8'hC7, "R3 right lo");

    set_mode(2'd3);
    conv(10'h1F0);
    conv(10'h2B4);
    rd(HI, 8'h00, "R4 trunc hi zero");
    conv(10'h0CC);
    rd(LO, 8'h33, "R4 trunc stores after hi read");

    // R7: interlock drops result, lo frozen
    set_mode(2'd0);
    conv(10'h123);
    rd(HI, f_hi(0, 10'h123), "R7 hi arms");
    conv(10'h3FE);
    rd(LO, f_lo(0, 10'h123), "R7 lo frozen");
    conv(10'h3FE);
    rd(HI, f_hi(0, 10'h3FE), "R8 released, R6 new stored");
    rd(LO, f_lo(0, 10'h3FE), "R8 release lo");

    // R9: release-cycle result dropped, next-cycle result stored
    conv(10'h0F1);
    rd(HI, f_hi(0, 10'h0F1), "R9 arm");
    @(negedge clk);
    rd_en = 1'b1; rd_addr = LO; done = 1'b1; res = 10'h2AA;
    sb.push_back('{f_lo(0, 10'h0F1), "R9 release lo"});
    @(negedge clk);
    rd_en = 1'b0; done = 1'b1; res = 10'h1C3;
    @(negedge clk);
    done = 1'b0;
    rd(HI, f_hi(0, 10'h1C3), "R9 next-cycle stored hi");
    rd(LO, f_lo(0, 10'h1C3), "R9 next-cycle stored lo");

    // R8: lo-only read does not arm
    rd(LO, f_lo(0, 10'h1C3), "R8 lo only");
    conv(10'h37A);
    rd(HI, f_hi(0, 10'h37A), "R8 no lock after lo only");

    // R10: mode change releases; new layout applies
    set_mode(2'd2);
    conv(10'h25B);
    rd(HI, f_hi(2, 10'h25B), "R10 released by mode change");
    rd(LO, f_lo(2, 10'h25B), "R10 new format");

    repeat (3) @(negedge clk);
    check(rd_data, 8'h00, "R5 idle end");
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule